// File: doc/BRIEF.md
# Prefixed Opcode Page Decoder

This block sits at the front of an 8-bit accumulator processor's instruction path. It takes one instruction byte per accepted cycle and sorts it into an opcode page, an operation group, an addressing mode and a target register. Two bytes act as page selectors. Byte 0x10 moves the next opcode into page 2 and byte 0x11 moves it into page 3. Every other opcode is decoded in whatever page is active and then returns the decoder to page 1.

A pending control or interrupt line can hold the decoder off. In that case the presented byte is dropped as if it had never arrived. An active-low halt, reset or non-maskable request always blocks decode. The fast and normal interrupt requests block decode only while their mask input is clear. Results appear as registered outputs one clock after the byte is accepted. A defined opcode gives a one-cycle decode pulse. An undefined opcode gives a one-cycle illegal pulse.

Top module: `prefix_page_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is zero. The first opcode after reset is decoded in page 1.
- R2: In page 1, a byte with upper nibble 0x8–0xF decodes as group 1 (accumulator op). The target is A (code 1) for nibbles 0x8–0xB and B (code 2) for 0xC–0xF. The low two bits of the nibble select the mode: 0 immediate (code 1), 1 direct (code 2), 2 indexed (code 3), 3 extended (code 4).
- R3: In page 1, upper nibble 0x4 decodes as group 2 (unary), inherent mode (code 0), target A. Nibble 0x5 is the same with target B. Nibbles 0x0, 0x6 and 0x7 are group 2 with no target (code 0), in direct, indexed and extended mode respectively.
- R4: In page 1, bytes 0x30–0x33 decode as group 3 (address load), indexed mode. The targets are X (3), Y (4), S (5) and U (6) in that byte order.
- R5: An accepted 0x10 makes page 2, and an accepted 0x11 makes page 3, the page of the next accepted opcode. A prefix byte produces neither pulse. When a prefix follows another prefix, the later one replaces the earlier.
- R6: In pages 2 and 3, bytes 0x83 and 0x8C are group 4 (wide compare) in immediate mode, and 0x3F is group 6 (software trap) in inherent mode. In page 2 only, bytes 0x21–0x2F are group 5 (long branch) in relative mode (code 5). All of these have no target.
- R7: A byte that is not defined in the active page raises `illegal` for one cycle. It leaves `dec_vld` low, reports the page it was decoded in, and drives group, mode and target to 0.
- R8: After any accepted non-prefix byte, whether legal or not, the next opcode is decoded in page 1.
- R9: While `halt_n`, `reset_n` or `nmi_n` is low, a presented byte is ignored. No pulse follows, and the pending page is unchanged.
- R10: A low `firq_n` ignores bytes only while `mask_f` is 0. A low `irq_n` ignores bytes only while `mask_i` is 0.
- R11: Outputs are registered one cycle after the accepted byte. A pulse lasts one cycle, and no pulse follows a cycle without `byte_vld`. The page output uses 1, 2 or 3, and is 0 when neither pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | Instruction byte present this cycle |
| byte_in | input | 8 | Instruction byte |
| mask_f | input | 1 | Fast-interrupt mask bit from the condition codes |
| mask_i | input | 1 | Normal-interrupt mask bit from the condition codes |
| halt_n | input | 1 | Halt request, active low |
| reset_n | input | 1 | Processor reset line, active low |
| nmi_n | input | 1 | Non-maskable request, active low |
| firq_n | input | 1 | Fast interrupt request, active low |
| irq_n | input | 1 | Normal interrupt request, active low |
| dec_vld | output | 1 | One-cycle pulse for a defined opcode |
| illegal | output | 1 | One-cycle pulse for an undefined opcode |
| page | output | 2 | Page the opcode was decoded in (1–3), 0 when idle |
| group | output | 3 | Operation group code |
| mode | output | 3 | Addressing-mode code |
| target | output | 3 | Target register code |

## Verification
The hardest case to reach is a suppressed byte that lands between a prefix and its opcode. Decode must drop that byte and still keep the pending page, so that the following opcode lands in page 2 or 3. Directed sequences place a prefix first, then a byte held off by each blocking line and by each unmasked interrupt in turn, then a page-2 or page-3 opcode. Random streams weight prefix bytes heavily and assert control lines rarely. This produces chains of prefixes broken by held-off bytes, and a reference model tracks the page through them.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int OP_W  = 8;
    localparam int NIB_W = OP_W / 2;

    localparam logic [OP_W-1:0] PFX_P2 = 8'h10;
    localparam logic [OP_W-1:0] PFX_P3 = 8'h11;
    localparam logic [OP_W-1:0] OP_CMPW_A = 8'h83;
    localparam logic [OP_W-1:0] OP_CMPW_B = 8'h8C;
    localparam logic [OP_W-1:0] OP_TRAP   = 8'h3F;

    typedef enum logic [1:0] {PG_NONE = 2'd0, PG_1 = 2'd1, PG_2 = 2'd2, PG_3 = 2'd3} page_e;

    typedef enum logic [2:0] {
        M_INH = 3'd0, M_IMM = 3'd1, M_DIR = 3'd2, M_IDX = 3'd3, M_EXT = 3'd4, M_REL = 3'd5
    } amode_e;

    typedef enum logic [2:0] {
        T_NONE = 3'd0, T_A = 3'd1, T_B = 3'd2, T_X = 3'd3, T_Y = 3'd4, T_S = 3'd5, T_U = 3'd6
    } tgt_e;

    typedef enum logic [2:0] {
        G_NONE = 3'd0, G_ACC = 3'd1, G_UNARY = 3'd2, G_LEA = 3'd3,
        G_CMPW = 3'd4, G_LBR = 3'd5, G_TRAP = 3'd6
    } grp_e;

    typedef struct packed {
        logic   legal;
        grp_e   grp;
        amode_e mode;
        tgt_e   tgt;
    } dec_t;

    localparam dec_t DEC_NONE = '{legal: 1'b0, grp: G_NONE, mode: M_INH, tgt: T_NONE};

    function automatic amode_e mem_mode(input logic [1:0] sel);
        case (sel)
            2'd0:    return M_IMM;
            2'd1:    return M_DIR;
            2'd2:    return M_IDX;
            default: return M_EXT;
        endcase
    endfunction

    function automatic tgt_e ptr_target(input logic [1:0] sel);
        case (sel)
            2'd0:    return T_X;
            2'd1:    return T_Y;
            2'd2:    return T_S;
            default: return T_U;
        endcase
    endfunction

    // Base page: accumulator ops, unary ops, address loads.
    function automatic dec_t decode_base(input logic [OP_W-1:0] op);
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
        dec_t d;
        hi = op[OP_W-1:NIB_W];
        lo = op[NIB_W-1:0];
        d  = DEC_NONE;
        if (hi[NIB_W-1]) begin
            d.legal = 1'b1;
            d.grp   = G_ACC;
            d.tgt   = hi[2] ? T_B : T_A;
            d.mode  = mem_mode(hi[1:0]);
        end else begin
            case (hi)
                4'h0: begin d.legal = 1'b1; d.grp = G_UNARY; d.mode = M_DIR; end
                4'h4: begin d.legal = 1'b1; d.grp = G_UNARY; d.mode = M_INH; d.tgt = T_A; end
                4'h5: begin d.legal = 1'b1; d.grp = G_UNARY; d.mode = M_INH; d.tgt = T_B; end
                4'h6: begin d.legal = 1'b1; d.grp = G_UNARY; d.mode = M_IDX; end
                4'h7: begin d.legal = 1'b1; d.grp = G_UNARY; d.mode = M_EXT; end
                4'h3: begin
                    if (lo[3:2] == 2'b00) begin
                        d.legal = 1'b1;
                        d.grp   = G_LEA;
                        d.mode  = M_IDX;
                        d.tgt   = ptr_target(lo[1:0]);
                    end
                end
                default: d = DEC_NONE;
            endcase
        end
        return d;
    endfunction

    // Extended pages 2 and 3.
    function automatic dec_t decode_ext(input page_e pg, input logic [OP_W-1:0] op);
        dec_t d;
        d = DEC_NONE;
        if (op == OP_CMPW_A || op == OP_CMPW_B) begin
            d.legal = 1'b1; d.grp = G_CMPW; d.mode = M_IMM;
        end else if (op == OP_TRAP) begin
            d.legal = 1'b1; d.grp = G_TRAP; d.mode = M_INH;
        end else if (pg == PG_2 && op[OP_W-1:NIB_W] == 4'h2 && op[NIB_W-1:0] != 4'h0) begin
            d.legal = 1'b1; d.grp = G_LBR; d.mode = M_REL;
        end
        return d;
    endfunction

endpackage

// File: rtl/opdec_gate.sv
module opdec_gate (
    input  logic mask_f,
    input  logic mask_i,
    input  logic halt_n,
    input  logic reset_n,
    input  logic nmi_n,
    input  logic firq_n,
    input  logic irq_n,
    output logic inhibit
);
    logic hard_block;
    logic soft_block;

    always_comb begin
        hard_block = ~halt_n | ~reset_n | ~nmi_n;
        soft_block = (~firq_n & ~mask_f) | (~irq_n & ~mask_i);
        inhibit    = hard_block | soft_block;
    end
endmodule

// File: rtl/opdec_page.sv
module opdec_page
    import opdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [OP_W-1:0] byte_in,
    output page_e           cur_pg,
    output logic            is_pfx
);
    page_e pg_q;

    assign is_pfx = (byte_in == PFX_P2) || (byte_in == PFX_P3);
    assign cur_pg = pg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q <= PG_1;
        end else if (take) begin
            if (byte_in == PFX_P2)      pg_q <= PG_2;
            else if (byte_in == PFX_P3) pg_q <= PG_3;
            else                        pg_q <= PG_1;
        end
    end

    // R5
    pfx2_page_chk: assert property (@(posedge clk) disable iff (rst)
        (take && byte_in == PFX_P2) |=> (cur_pg == PG_2));

    // R5
    pfx3_page_chk: assert property (@(posedge clk) disable iff (rst)
        (take && byte_in == PFX_P3) |=> (cur_pg == PG_3));

    // R8
    back_to_base_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !is_pfx) |=> (cur_pg == PG_1));

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(cur_pg));
endmodule

// File: rtl/prefix_page_decoder.sv
module prefix_page_decoder
    import opdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_vld,
    input  logic [OP_W-1:0] byte_in,
    input  logic            mask_f,
    input  logic            mask_i,
    input  logic            halt_n,
    input  logic            reset_n,
    input  logic            nmi_n,
    input  logic            firq_n,
    input  logic            irq_n,
    output logic            dec_vld,
    output logic            illegal,
    output logic [1:0]      page,
    output logic [2:0]      group,
    output logic [2:0]      mode,
    output logic [2:0]      target
);
    logic  inhibit;
    logic  take;
    logic  is_pfx;
    page_e cur_pg;
    dec_t  dec;

    opdec_gate u_gate (
        .mask_f  (mask_f),
        .mask_i  (mask_i),
        .halt_n  (halt_n),
        .reset_n (reset_n),
        .nmi_n   (nmi_n),
        .firq_n  (firq_n),
        .irq_n   (irq_n),
        .inhibit (inhibit)
    );

    assign take = byte_vld & ~inhibit;

    opdec_page u_page (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .byte_in (byte_in),
        .cur_pg  (cur_pg),
        .is_pfx  (is_pfx)
    );

    always_comb begin
        if (cur_pg == PG_1) dec = decode_base(byte_in);
        else                dec = decode_ext(cur_pg, byte_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld <= 1'b0;
            illegal <= 1'b0;
            page    <= '0;
            group   <= '0;
            mode    <= '0;
            target  <= '0;
        end else begin
            dec_vld <= 1'b0;
            illegal <= 1'b0;
            page    <= '0;
            group   <= '0;
            mode    <= '0;
            target  <= '0;
            if (take && !is_pfx) begin
                page <= cur_pg;
                if (dec.legal) begin
                    dec_vld <= 1'b1;
                    group   <= dec.grp;
                    mode    <= dec.mode;
                    target  <= dec.tgt;
                end else begin
                    illegal <= 1'b1;
                end
            end
        end
    end

    // R9
    held_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && inhibit) |=> !(dec_vld || illegal));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> !(dec_vld || illegal));

    // R5
    prefix_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (take && is_pfx) |=> !(dec_vld || illegal));

    // R7
    illegal_fields_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!dec_vld && group == 3'd0 && mode == 3'd0 && target == 3'd0 && page != 2'd0));

    // R2
    acc_target_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && group == G_ACC) |-> (page == PG_1 && (target == T_A || target == T_B)));

    // R4
    lea_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && group == G_LEA) |-> (mode == M_IDX && page == PG_1));

    // R11
    page_code_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_vld || illegal) == (page != 2'd0));
endmodule

// File: tb/prefix_page_decoder_test.sv
`timescale 1ns/1ps
module prefix_page_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       mask_f = 1'b0, mask_i = 1'b0;
    logic       halt_n = 1'b1, reset_n = 1'b1, nmi_n = 1'b1, firq_n = 1'b1, irq_n = 1'b1;
    logic       dec_vld, illegal;
    logic [1:0] page;
    logic [2:0] group, mode, target;

    int compared = 0;
    int mismatched = 0;
    int model_pg = 1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prefix_page_decoder uut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .mask_f(mask_f), .mask_i(mask_i), .halt_n(halt_n), .reset_n(reset_n),
        .nmi_n(nmi_n), .firq_n(firq_n), .irq_n(irq_n),
        .dec_vld(dec_vld), .illegal(illegal), .page(page),
        .group(group), .mode(mode), .target(target)
    );

    // {dec_vld, illegal, page[1:0], group[2:0], mode[2:0], target[2:0]}
    function automatic logic [12:0] expect_out(int pg, logic [7:0] b);
        int hn;
        int grp;
        int md;
        int tg;
        bit ok;
        hn = int'(b) / 16;
        grp = 0; md = 0; tg = 0; ok = 1'b0;
        if (pg == 1) begin
            if (hn >= 8) begin
                ok = 1'b1; grp = 1;
                tg = (hn >= 12) ? 2 : 1;
                md = (hn % 4) + 1;
            end else if (hn == 0) begin ok = 1'b1; grp = 2; md = 2; end
            else if (hn == 4) begin ok = 1'b1; grp = 2; md = 0; tg = 1; end
            else if (hn == 5) begin ok = 1'b1; grp = 2; md = 0; tg = 2; end
            else if (hn == 6) begin ok = 1'b1; grp = 2; md = 3; end
            else if (hn == 7) begin ok = 1'b1; grp = 2; md = 4; end
            else if (b >= 8'h30 && b <= 8'h33) begin
                ok = 1'b1; grp = 3; md = 3; tg = 3 + int'(b) - 48;
            end
        end else begin
            if (b == 8'h83 || b == 8'h8C) begin ok = 1'b1; grp = 4; md = 1; end
            else if (b == 8'h3F) begin ok = 1'b1; grp = 6; md = 0; end
            else if (pg == 2 && b >= 8'h21 && b <= 8'h2F) begin ok = 1'b1; grp = 5; md = 5; end
        end
        return {ok, !ok, 2'(pg), 3'(grp), 3'(md), 3'(tg)};
    endfunction

    task automatic check(input logic [12:0] exp, input string req);
        logic [12:0] got;
        got = {dec_vld, illegal, page, group, mode, target};
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // ctl = {halt_n, reset_n, nmi_n, firq_n, irq_n}
    task automatic step(input logic v, input logic [7:0] b, input logic [4:0] ctl,
                        input logic mf, input logic mi, input string req);
        logic [12:0] exp;
        bit inh;
        @(negedge clk);
        byte_vld = v; byte_in = b; mask_f = mf; mask_i = mi;
        {halt_n, reset_n, nmi_n, firq_n, irq_n} = ctl;
        inh = !ctl[4] || !ctl[3] || !ctl[2] || (!ctl[1] && !mf) || (!ctl[0] && !mi);
        exp = '0;
        if (v && !inh) begin
            if (b == 8'h10) model_pg = 2;
            else if (b == 8'h11) model_pg = 3;
            else begin
                exp = expect_out(model_pg, b);
                model_pg = 1;
            end
        end
        @(posedge clk);
        #1;
        check(exp, req);
    endtask

    task automatic op(input logic [7:0] b, input string req);
        step(1'b1, b, 5'b11111, 1'b0, 1'b0, req);
    endtask

    initial begin
        #800000;
        if (!done) begin
            mismatched++;
            $display("FAIL R11 watchdog: got no end of run, expected end of run");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        repeat (3) @(posedge clk);
        #1;
        check(13'd0, "R1");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(13'd0, "R1");

        // R1 first opcode lands in page 1; R2 accumulator forms
        op(8'h86, "R1");
        op(8'hF7, "R2");
        op(8'h9B, "R2");
        op(8'hEC, "R2");
        op(8'hA0, "R2");
        // R3 unary forms
        op(8'h4F, "R3");
        op(8'h5A, "R3");
        op(8'h00, "R3");
        op(8'h6D, "R3");
        op(8'h7E, "R3");
        // R4 address loads
        for (int k = 0; k < 4; k++) op(8'h30 + 8'(k), "R4");
        op(8'h34, "R4");
        // R5 and R6 prefixes and extended pages
        op(8'h10, "R5"); op(8'h83, "R6");
        op(8'h11, "R5"); op(8'h8C, "R6");
        op(8'h10, "R5"); op(8'h11, "R5"); op(8'h3F, "R5");
        op(8'h11, "R5"); op(8'h10, "R5"); op(8'h27, "R5");
        op(8'h10, "R6"); op(8'h21, "R6");
        op(8'h10, "R6"); op(8'h2F, "R6");
        op(8'h11, "R6"); op(8'h3F, "R6");
        // R7 undefined opcodes, R8 return to base page
        op(8'h10, "R7"); op(8'h86, "R7"); op(8'h86, "R8");
        op(8'h11, "R7"); op(8'h21, "R7"); op(8'h4C, "R8");
        op(8'h10, "R7"); op(8'h20, "R7");
        op(8'h20, "R7");
        op(8'h12, "R7");
        // R9 hard blocking lines keep the pending page
        op(8'h10, "R9");
        step(1'b1, 8'h86, 5'b01111, 1'b1, 1'b1, "R9");
        step(1'b1, 8'h86, 5'b10111, 1'b1, 1'b1, "R9");
        step(1'b1, 8'h11, 5'b11011, 1'b1, 1'b1, "R9");
        op(8'h83, "R9");
        // R10 maskable requests
        op(8'h11, "R10");
        step(1'b1, 8'h4F, 5'b11101, 1'b0, 1'b1, "R10");
        step(1'b1, 8'h4F, 5'b11110, 1'b1, 1'b0, "R10");
        op(8'h8C, "R10");
        step(1'b1, 8'h4F, 5'b11101, 1'b1, 1'b0, "R10");
        step(1'b1, 8'h5F, 5'b11110, 1'b0, 1'b1, "R10");
        // R11 idle cycles and single-cycle pulse
        op(8'hC6, "R11");
        step(1'b0, 8'h86, 5'b11111, 1'b0, 1'b0, "R11");
        step(1'b0, 8'h4F, 5'b11111, 1'b0, 1'b0, "R11");

        // random streams
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] b;
            logic [4:0] ctl;
            int sel;
            sel = int'($urandom % 8);
            if (sel == 0)      b = 8'h10;
            else if (sel == 1) b = 8'h11;
            else               b = 8'($urandom % 256);
            for (int j = 0; j < 5; j++) ctl[j] = ($urandom % 16) != 0;
            step(($urandom % 8) != 0, b, ctl, 1'($urandom % 2), 1'($urandom % 2), "R11");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule